// File: doc/BRIEF.md
# Tag-Matching Reservation Station Pool

This block holds issued operations until their source operands are known, then passes them to the execution units. The stations are split into three unit classes. Class code 0 is the adder, with `N_ADD` stations (3 by default). Class code 1 is the multiplier, with `N_MUL` stations (2). Class code 2 is the integer/load/store unit, with `N_INT` stations (3). Each station stores an operation code, two source operands and the reorder-buffer tag of the result it will produce. A source that was not yet computed at issue time is held as the reorder-buffer tag of its producer, not as a value. For a store, the two operands are the address base and the data word. Either of them may wait on a tag.

Every station snoops the single result bus. When a broadcast tag matches a waiting source, the station copies the value in. When both sources are held, the station becomes eligible for dispatch. Each class picks the eligible station whose tag is oldest relative to the reorder-buffer head and drives it onto that class's dispatch port. The station is freed at the next edge. A flush empties the pool.

Each station runs a three-state machine:
- `SLOT_FREE`: the station is empty.
- `SLOT_WAIT`: at least one source is still pending.
- `SLOT_READY`: both sources are held.

The transitions are:
- issue-with-pending takes `SLOT_FREE` to `SLOT_WAIT`.
- issue-all-known takes `SLOT_FREE` to `SLOT_READY`.
- last-capture takes `SLOT_WAIT` to `SLOT_READY`.
- dispatch takes `SLOT_READY` to `SLOT_FREE`.
- flush takes any state to `SLOT_FREE`.

Top module: `rsp_pool`

## Requirements
- R1: Class codes are 0 = adder, 1 = multiplier and 2 = integer. An issue request (`iss_valid` high, not stalled, no flush) fills the lowest-numbered free station of its class. Adder, multiplier and integer classes hold `N_ADD`, `N_MUL` and `N_INT` live operations respectively.
- R2: A source flagged ready at issue keeps the supplied value. That value appears on the class's `dsp_vj`/`dsp_vk` slice when the operation dispatches, together with the issued operation code.
- R3: A pending source captures `bus_val` at an edge where `bus_valid` is high and `bus_tag` equals its wait tag. A broadcast with any other tag leaves the source pending.
- R4: If the issue request names a pending tag that equals the tag on the result bus in the same cycle, the station takes the bus value directly. It is then eligible in the very next cycle.
- R5: A station is eligible from the cycle after both its sources are held. While any station of class c is eligible and `flush` is low, `dsp_go[c]` is high in that same cycle. The class slices of `dsp_op`, `dsp_vj`, `dsp_vk` and `dsp_dst` (class c at bit offset c×width) then carry that station's fields.
- R6: Among eligible stations of one class, the one with the smallest (tag − `rob_head`) mod 2^`TAG_W` is dispatched. At most one station per class is dispatched per cycle.
- R7: A dispatched station is free after the next edge. It cannot dispatch twice.
- R8: `iss_stall` is high in the same cycle as `iss_valid` when every station of the requested class is busy. A stalled request changes no station.
- R9: While `flush` is high, every `dsp_go` bit is low and an issue request is ignored. After that edge, every station is free.
- R10: After reset, all stations are free. No `dsp_go` bit is set, and `iss_stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard every station |
| iss_valid | input | 1 | Issue request |
| iss_cls | input | 2 | Unit class of the request (0 add, 1 mul, 2 int) |
| iss_op | input | OP_W | Operation code |
| iss_dst | input | TAG_W | Reorder-buffer tag of the result |
| iss_j_rdy | input | 1 | First source value is known |
| iss_j_val | input | DATA_W | First source value |
| iss_j_tag | input | TAG_W | Producer tag of first source when not known |
| iss_k_rdy | input | 1 | Second source value is known |
| iss_k_val | input | DATA_W | Second source value |
| iss_k_tag | input | TAG_W | Producer tag of second source when not known |
| iss_stall | output | 1 | Requested class has no free station |
| bus_valid | input | 1 | Result bus carries a broadcast |
| bus_tag | input | TAG_W | Tag of the broadcast result |
| bus_val | input | DATA_W | Broadcast result value |
| rob_head | input | TAG_W | Tag of the oldest uncommitted instruction |
| dsp_go | output | 3 | Per-class dispatch strobe |
| dsp_op | output | 3*OP_W | Per-class dispatched operation code |
| dsp_vj | output | 3*DATA_W | Per-class dispatched first source |
| dsp_vk | output | 3*DATA_W | Per-class dispatched second source |
| dsp_dst | output | 3*TAG_W | Per-class dispatched result tag |

## Verification
The assertions assume several things about the inputs:
- `iss_cls` never carries the unused code 3.
- The tags of all live operations are distinct.
- All live tags lie within one window of 2^`TAG_W` counted forward from `rob_head`.

The stimulus keeps to these rules in three ways:
- It draws a fresh result tag for every accepted issue from a counter.
- It holds `rob_head` at the oldest live tag.
- It withholds issue whenever the span from the head to the next tag would reach 12.

Result-bus tags are drawn from tags that stations are actually waiting on. Some issue requests are deliberately given the tag being broadcast in that same cycle.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;

    localparam int NUM_CLS = 3;
endpackage

// File: rtl/rsp_slot.sv
module rsp_slot
    import rsp_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16,
    parameter int OP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              load,
    input  logic [OP_W-1:0]   ld_op,
    input  logic [TAG_W-1:0]  ld_dst,
    input  logic              ld_j_rdy,
    input  logic [DATA_W-1:0] ld_j_val,
    input  logic [TAG_W-1:0]  ld_j_tag,
    input  logic              ld_k_rdy,
    input  logic [DATA_W-1:0] ld_k_val,
    input  logic [TAG_W-1:0]  ld_k_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_val,
    input  logic              grant,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   op,
    output logic [DATA_W-1:0] vj,
    output logic [DATA_W-1:0] vk,
    output logic [TAG_W-1:0]  dst
);
    slot_state_e st_q, st_d;
    logic jw_q, kw_q, jw_d, kw_d;
    logic [TAG_W-1:0] qj_q, qk_q;

    logic j_hit, k_hit, ld_j_hit, ld_k_hit, fill;
    assign j_hit    = bus_valid && jw_q && (bus_tag == qj_q);
    assign k_hit    = bus_valid && kw_q && (bus_tag == qk_q);
    assign ld_j_hit = bus_valid && !ld_j_rdy && (bus_tag == ld_j_tag);
    assign ld_k_hit = bus_valid && !ld_k_rdy && (bus_tag == ld_k_tag);
    assign fill     = (st_q == SLOT_FREE) && load && !flush;

    always_comb begin
        st_d = st_q;
        jw_d = jw_q;
        kw_d = kw_q;
        unique case (st_q)
            SLOT_FREE: begin
                if (load) begin
                    jw_d = !ld_j_rdy && !ld_j_hit;
                    kw_d = !ld_k_rdy && !ld_k_hit;
                    st_d = (jw_d || kw_d) ? SLOT_WAIT : SLOT_READY;
                end
            end
            SLOT_WAIT: begin
                jw_d = jw_q && !j_hit;
                kw_d = kw_q && !k_hit;
                if (!jw_d && !kw_d) st_d = SLOT_READY;
            end
            SLOT_READY: begin
                if (grant) st_d = SLOT_FREE;
            end
            default: st_d = SLOT_FREE;
        endcase
        if (flush) begin
            st_d = SLOT_FREE;
            jw_d = 1'b0;
            kw_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SLOT_FREE;
            jw_q <= 1'b0;
            kw_q <= 1'b0;
        end else begin
            st_q <= st_d;
            jw_q <= jw_d;
            kw_q <= kw_d;
        end
    end

    always_ff @(posedge clk) begin
        if (fill) begin
            op   <= ld_op;
            dst  <= ld_dst;
            qj_q <= ld_j_tag;
            qk_q <= ld_k_tag;
            vj   <= ld_j_rdy ? ld_j_val : bus_val;
            vk   <= ld_k_rdy ? ld_k_val : bus_val;
        end else begin
            if (j_hit) vj <= bus_val;
            if (k_hit) vk <= bus_val;
        end
    end

    always_comb begin
        busy  = (st_q != SLOT_FREE);
        ready = (st_q == SLOT_READY);
    end
endmodule

// File: rtl/rsp_pick.sv
module rsp_pick #(
    parameter int N     = 3,
    parameter int TAG_W = 4
) (
    input  logic [N-1:0]       req,
    input  logic [N*TAG_W-1:0] dst_flat,
    input  logic [TAG_W-1:0]   head,
    output logic [N-1:0]       gnt,
    output logic               any
);
    localparam int SW = (N > 1) ? $clog2(N) : 1;

    logic [TAG_W-1:0] best_age;
    logic [SW-1:0]    sel;

    always_comb begin
        any      = 1'b0;
        best_age = '0;
        sel      = '0;
        gnt      = '0;
        for (int i = 0; i < N; i++) begin
            logic [TAG_W-1:0] age;
            age = dst_flat[i*TAG_W +: TAG_W] - head;
            if (req[i] && (!any || age < best_age)) begin
                any      = 1'b1;
                best_age = age;
                sel      = SW'(i);
            end
        end
        if (any) gnt[sel] = 1'b1;
    end
endmodule

// File: rtl/rsp_pool.sv
module rsp_pool
    import rsp_pkg::*;
#(
    parameter int N_ADD  = 3,
    parameter int N_MUL  = 2,
    parameter int N_INT  = 3,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16,
    parameter int OP_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      iss_valid,
    input  logic [1:0]                iss_cls,
    input  logic [OP_W-1:0]           iss_op,
    input  logic [TAG_W-1:0]          iss_dst,
    input  logic                      iss_j_rdy,
    input  logic [DATA_W-1:0]         iss_j_val,
    input  logic [TAG_W-1:0]          iss_j_tag,
    input  logic                      iss_k_rdy,
    input  logic [DATA_W-1:0]         iss_k_val,
    input  logic [TAG_W-1:0]          iss_k_tag,
    output logic                      iss_stall,
    input  logic                      bus_valid,
    input  logic [TAG_W-1:0]          bus_tag,
    input  logic [DATA_W-1:0]         bus_val,
    input  logic [TAG_W-1:0]          rob_head,
    output logic [NUM_CLS-1:0]        dsp_go,
    output logic [NUM_CLS*OP_W-1:0]   dsp_op,
    output logic [NUM_CLS*DATA_W-1:0] dsp_vj,
    output logic [NUM_CLS*DATA_W-1:0] dsp_vk,
    output logic [NUM_CLS*TAG_W-1:0]  dsp_dst
);
    localparam int NUM_SLOT = N_ADD + N_MUL + N_INT;

    logic [NUM_SLOT-1:0]        slot_busy, slot_ready, slot_load, slot_gnt;
    logic [NUM_SLOT*OP_W-1:0]   slot_op_f;
    logic [NUM_SLOT*DATA_W-1:0] slot_vj_f, slot_vk_f;
    logic [NUM_SLOT*TAG_W-1:0]  slot_dst_f;
    logic [NUM_CLS-1:0]         cls_full;
    logic [3:0]                 full_ext;

    assign full_ext  = {1'b0, cls_full};
    assign iss_stall = iss_valid && full_ext[iss_cls];

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        rsp_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .load     (slot_load[s]),
            .ld_op    (iss_op),
            .ld_dst   (iss_dst),
            .ld_j_rdy (iss_j_rdy),
            .ld_j_val (iss_j_val),
            .ld_j_tag (iss_j_tag),
            .ld_k_rdy (iss_k_rdy),
            .ld_k_val (iss_k_val),
            .ld_k_tag (iss_k_tag),
            .bus_valid(bus_valid),
            .bus_tag  (bus_tag),
            .bus_val  (bus_val),
            .grant    (slot_gnt[s]),
            .busy     (slot_busy[s]),
            .ready    (slot_ready[s]),
            .op       (slot_op_f[s*OP_W +: OP_W]),
            .vj       (slot_vj_f[s*DATA_W +: DATA_W]),
            .vk       (slot_vk_f[s*DATA_W +: DATA_W]),
            .dst      (slot_dst_f[s*TAG_W +: TAG_W])
        );
    end

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        localparam int CN = (c == 0) ? N_ADD : (c == 1) ? N_MUL : N_INT;
        localparam int CB = (c == 0) ? 0 : (c == 1) ? N_ADD : N_ADD + N_MUL;

        logic [CN-1:0]     free_v, ld_v, g_v;
        logic              any_rdy;
        logic [OP_W-1:0]   op_m;
        logic [DATA_W-1:0] vj_m, vk_m;
        logic [TAG_W-1:0]  dst_m;

        assign free_v      = ~slot_busy[CB +: CN];
        assign cls_full[c] = ~|free_v;

        always_comb begin
            logic taken;
            taken = 1'b0;
            ld_v  = '0;
            for (int i = 0; i < CN; i++) begin
                if (free_v[i] && !taken) begin
                    ld_v[i] = iss_valid && !flush && (iss_cls == 2'(c));
                    taken   = 1'b1;
                end
            end
        end
        assign slot_load[CB +: CN] = ld_v;

        rsp_pick #(.N(CN), .TAG_W(TAG_W)) u_pick (
            .req     (slot_ready[CB +: CN]),
            .dst_flat(slot_dst_f[CB*TAG_W +: CN*TAG_W]),
            .head    (rob_head),
            .gnt     (g_v),
            .any     (any_rdy)
        );
        assign slot_gnt[CB +: CN] = g_v & {CN{!flush}};
        assign dsp_go[c]          = any_rdy && !flush;

        always_comb begin
            op_m  = '0;
            vj_m  = '0;
            vk_m  = '0;
            dst_m = '0;
            for (int i = 0; i < CN; i++) begin
                if (g_v[i]) begin
                    op_m  |= slot_op_f[(CB+i)*OP_W +: OP_W];
                    vj_m  |= slot_vj_f[(CB+i)*DATA_W +: DATA_W];
                    vk_m  |= slot_vk_f[(CB+i)*DATA_W +: DATA_W];
                    dst_m |= slot_dst_f[(CB+i)*TAG_W +: TAG_W];
                end
            end
        end
        assign dsp_op[c*OP_W +: OP_W]       = op_m;
        assign dsp_vj[c*DATA_W +: DATA_W]   = vj_m;
        assign dsp_vk[c*DATA_W +: DATA_W]   = vk_m;
        assign dsp_dst[c*TAG_W +: TAG_W]    = dst_m;
    end
endmodule

// File: rtl/rsp_pool_chk.sv
module rsp_pool_chk #(
    parameter int N_ADD = 3,
    parameter int N_MUL = 2,
    parameter int N_INT = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           flush,
    input logic                           iss_valid,
    input logic                           iss_stall,
    input logic [2:0]                     dsp_go,
    input logic [N_ADD+N_MUL+N_INT-1:0]   slot_busy,
    input logic [N_ADD+N_MUL+N_INT-1:0]   slot_gnt
);
    localparam int NUM_SLOT = N_ADD + N_MUL + N_INT;

    assert_stall_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        iss_stall |-> iss_valid);

    assert_flush_silences_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (dsp_go == 3'b000));

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (slot_busy == '0));

    assert_dispatch_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_gnt) |=> ((slot_busy & $past(slot_gnt)) == '0));

    assert_one_per_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_gnt[0 +: N_ADD]) && $onehot0(slot_gnt[N_ADD +: N_MUL])
        && $onehot0(slot_gnt[N_ADD+N_MUL +: N_INT]));

    assert_go_has_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_go[0] == |slot_gnt[0 +: N_ADD]) && (dsp_go[1] == |slot_gnt[N_ADD +: N_MUL])
        && (dsp_go[2] == |slot_gnt[N_ADD+N_MUL +: N_INT]));

    assert_grant_on_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_gnt & ~slot_busy) == {NUM_SLOT{1'b0}});
endmodule

bind rsp_pool rsp_pool_chk #(.N_ADD(N_ADD), .N_MUL(N_MUL), .N_INT(N_INT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .iss_valid(iss_valid),
    .iss_stall(iss_stall),
    .dsp_go   (dsp_go),
    .slot_busy(slot_busy),
    .slot_gnt (slot_gnt)
);

// File: tb/tb_rsp_pool.sv
`timescale 1ns/1ps
module tb_rsp_pool;
    localparam int TAG_W = 4, DATA_W = 16, OP_W = 4;
    localparam int TM = (1 << TAG_W) - 1;
    localparam int NS = 8;
    localparam int CB [3] = '{0, 3, 5};
    localparam int CN [3] = '{3, 2, 3};

    logic clk = 0, rst_n = 0, flush = 0;
    logic iss_valid = 0, iss_j_rdy = 0, iss_k_rdy = 0, bus_valid = 0;
    logic [1:0] iss_cls = 0;
    logic [OP_W-1:0] iss_op = 0;
    logic [TAG_W-1:0] iss_dst = 0, iss_j_tag = 0, iss_k_tag = 0, bus_tag = 0, rob_head = 0;
    logic [DATA_W-1:0] iss_j_val = 0, iss_k_val = 0, bus_val = 0;
    logic iss_stall;
    logic [2:0] dsp_go;
    logic [3*OP_W-1:0] dsp_op;
    logic [3*DATA_W-1:0] dsp_vj, dsp_vk;
    logic [3*TAG_W-1:0] dsp_dst;

    rsp_pool dut (.*);

    always #2.5 clk = ~clk;

    int n_chk = 0, n_err = 0;
    bit m_busy[NS], m_jw[NS], m_kw[NS];
    int m_op[NS], m_vj[NS], m_vk[NS], m_qj[NS], m_qk[NS], m_dst[NS];
    int g_idx[3];
    bit exp_stall;
    int next_tag = 11;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int cls_of(int s);
        return (s < 3) ? 0 : (s < 5) ? 1 : 2;
    endfunction

    // Settle after inputs, then compare every output against the model.
    task automatic settle();
        #1;
        exp_stall = 0;
        if (iss_valid && iss_cls < 3) begin
            exp_stall = 1;
            for (int s = CB[iss_cls]; s < CB[iss_cls] + CN[iss_cls]; s++)
                if (!m_busy[s]) exp_stall = 0;
        end
        chk("R8", iss_stall, exp_stall);
        for (int c = 0; c < 3; c++) begin
            int best, best_age;
            best = -1; best_age = 0;
            for (int s = CB[c]; s < CB[c] + CN[c]; s++) begin
                int age;
                age = (m_dst[s] - rob_head) & TM;
                if (m_busy[s] && !m_jw[s] && !m_kw[s] && (best < 0 || age < best_age)) begin
                    best = s; best_age = age;
                end
            end
            g_idx[c] = flush ? -1 : best;
            chk("R5", dsp_go[c], g_idx[c] >= 0);
            if (g_idx[c] >= 0) begin
                chk("R2", dsp_op[c*OP_W +: OP_W], m_op[best]);
                chk("R3", dsp_vj[c*DATA_W +: DATA_W], m_vj[best]);
                chk("R3", dsp_vk[c*DATA_W +: DATA_W], m_vk[best]);
                chk("R6", dsp_dst[c*TAG_W +: TAG_W], m_dst[best]);
            end
        end
    endtask

    task automatic advance();
        int alloc;
        @(posedge clk);
        alloc = -1;
        if (rst_n && iss_valid && !exp_stall && !flush && iss_cls < 3)
            for (int s = CB[iss_cls] + CN[iss_cls] - 1; s >= CB[iss_cls]; s--)
                if (!m_busy[s]) alloc = s;
        if (!rst_n || flush) begin
            for (int s = 0; s < NS; s++) begin m_busy[s] = 0; m_jw[s] = 0; m_kw[s] = 0; end
        end else begin
            for (int s = 0; s < NS; s++) begin
                if (g_idx[cls_of(s)] == s) m_busy[s] = 0;
                else if (m_busy[s] && bus_valid) begin
                    if (m_jw[s] && m_qj[s] == bus_tag) begin m_vj[s] = bus_val; m_jw[s] = 0; end
                    if (m_kw[s] && m_qk[s] == bus_tag) begin m_vk[s] = bus_val; m_kw[s] = 0; end
                end
            end
            if (alloc >= 0) begin
                m_busy[alloc] = 1; m_op[alloc] = iss_op; m_dst[alloc] = iss_dst;
                m_qj[alloc] = iss_j_tag; m_qk[alloc] = iss_k_tag;
                m_jw[alloc] = !iss_j_rdy && !(bus_valid && bus_tag == iss_j_tag);
                m_kw[alloc] = !iss_k_rdy && !(bus_valid && bus_tag == iss_k_tag);
                m_vj[alloc] = iss_j_rdy ? iss_j_val : bus_val;
                m_vk[alloc] = iss_k_rdy ? iss_k_val : bus_val;
                next_tag = (iss_dst + 1) & TM;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        iss_valid = 0; bus_valid = 0; flush = 0;
    endtask

    task automatic iss(int c, int op, int dst, bit jr, int jv, int jt, bit kr, int kv, int kt);
        iss_valid = 1; iss_cls = 2'(c); iss_op = OP_W'(op); iss_dst = TAG_W'(dst);
        iss_j_rdy = jr; iss_j_val = DATA_W'(jv); iss_j_tag = TAG_W'(jt);
        iss_k_rdy = kr; iss_k_val = DATA_W'(kv); iss_k_tag = TAG_W'(kt);
    endtask

    task automatic bus(int t, int v);
        bus_valid = 1; bus_tag = TAG_W'(t); bus_val = DATA_W'(v);
    endtask

    initial begin
        #(5.0 * 200000);
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++) begin m_busy[s] = 0; m_jw[s] = 0; m_kw[s] = 0; m_dst[s] = 0; end
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            settle();
            chk("R10", dsp_go, 0); chk("R10", iss_stall, 0);
            advance();
        end
        rst_n = 1;
        settle(); chk("R10", dsp_go, 0); advance();

        // R1 / R8: fill the adder class, then overflow it
        for (int i = 0; i < 3; i++) begin
            iss(0, i + 1, i, 0, 0, 9, 1, 100 + i, 0); settle(); advance();
        end
        iss(0, 7, 3, 1, 1, 0, 1, 1, 0); settle(); chk("R1", iss_stall, 1); advance();
        iss(1, 5, 4, 1, 7, 0, 1, 8, 0); settle(); chk("R1", iss_stall, 0); advance();
        idle(); settle();
        chk("R2", dsp_go[1], 1); chk("R2", dsp_vj[DATA_W +: DATA_W], 7); chk("R2", dsp_vk[DATA_W +: DATA_W], 8);
        advance();
        settle(); chk("R7", dsp_go[1], 0); advance();

        // R3: non-matching then matching broadcast
        bus(5, 16'h0BAD); settle(); advance();
        idle(); settle(); chk("R3", dsp_go[0], 0); advance();
        bus(9, 16'h0055); settle(); advance();
        idle(); settle();
        chk("R3", dsp_go[0], 1); chk("R3", dsp_vj[0 +: DATA_W], 16'h0055); chk("R6", dsp_dst[0 +: TAG_W], 0);
        advance();
        settle(); chk("R6", dsp_dst[0 +: TAG_W], 1); advance();
        settle(); chk("R6", dsp_dst[0 +: TAG_W], 2); advance();
        settle(); chk("R7", dsp_go[0], 0); advance();

        // R4: bypass from result bus at issue
        iss(2, 3, 6, 0, 0, 3, 1, 2, 0); bus(3, 16'h1234); settle(); advance();
        idle(); settle();
        chk("R4", dsp_go[2], 1); chk("R4", dsp_vj[2*DATA_W +: DATA_W], 16'h1234);
        advance();

        // R6: age order across tag wrap
        rob_head = 14;
        iss(1, 1, 1, 0, 0, 11, 1, 3, 0); settle(); advance();
        iss(1, 2, 15, 0, 0, 11, 1, 4, 0); settle(); advance();
        idle(); bus(11, 16'h0777); settle(); advance();
        idle(); settle(); chk("R6", dsp_dst[TAG_W +: TAG_W], 15); advance();
        settle(); chk("R6", dsp_dst[TAG_W +: TAG_W], 1); advance();
        rob_head = 0;

        // R9: flush hides a ready station, then all stations are free
        for (int i = 0; i < 3; i++) begin
            iss(0, 4, 8 + i, 0, 0, 12, 1, 0, 0); settle(); advance();
        end
        iss(2, 6, 11, 1, 5, 0, 1, 6, 0); settle(); advance();
        idle(); flush = 1; iss(1, 1, 12, 1, 1, 0, 1, 1, 0);
        settle(); chk("R9", dsp_go, 0); advance();
        idle(); settle(); chk("R9", dsp_go, 0); advance();
        rob_head = 8;
        for (int i = 0; i < 3; i++) begin
            iss(0, 4, 8 + i, 0, 0, 12, 1, 0, 0); settle(); chk("R9", iss_stall, 0); advance();
        end
        idle();

        // Random traffic
        for (int cyc = 0; cyc < 4000; cyc++) begin
            int oldest, back, span, off;
            oldest = -1; back = -1;
            for (int s = 0; s < NS; s++)
                if (m_busy[s] && ((next_tag - m_dst[s]) & TM) > back) begin
                    back = (next_tag - m_dst[s]) & TM; oldest = m_dst[s];
                end
            rob_head = TAG_W'((oldest < 0) ? next_tag : oldest);
            span = (next_tag - rob_head) & TM;
            flush = ($urandom % 150) == 0;
            bus_valid = 0;
            off = $urandom % NS;
            for (int k = 0; k < NS; k++) begin
                int s;
                s = (off + k) % NS;
                if (!bus_valid && m_busy[s] && (m_jw[s] || m_kw[s]) && ($urandom % 3 != 0)) begin
                    bus(m_jw[s] ? m_qj[s] : m_qk[s], $urandom);
                end
            end
            iss_valid = (span < 12) && ($urandom % 4 != 0);
            iss_cls = 2'($urandom % 3); iss_op = OP_W'($urandom); iss_dst = TAG_W'(next_tag);
            iss_j_rdy = $urandom % 2; iss_j_val = DATA_W'($urandom); iss_j_tag = TAG_W'($urandom);
            iss_k_rdy = $urandom % 2; iss_k_val = DATA_W'($urandom); iss_k_tag = TAG_W'($urandom);
            if (bus_valid && ($urandom % 3 == 0)) iss_j_tag = bus_tag; // R4 bypass
            if (!iss_j_rdy && !iss_k_rdy && !bus_valid) iss_k_rdy = 1;
            settle(); advance();
        end
        idle();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule